// File: doc/BRIEF.md
# Static Power-Down Sequencer

This block takes a processor core from normal execution into one of three graded idle levels and brings it back. Software writes a two-bit level code and raises an enable. The sequencer then waits until the pipeline reports that no instruction is in flight. For the two deeper levels it also exchanges an active-low quiesce request and acknowledge with the system. Only after that does it switch off the clock groups that the chosen level does not need.

While idle it watches the wake inputs that apply to that level. The first qualified event restores every clock group on the next cycle and raises a one-cycle request to jump to the vector of the highest-ranked cause. When the level was one of the two deeper ones, the bus interface is released only after the bus and core clocks report that they are in step. If a wake event arrives while the sequencer is still draining or waiting for the acknowledge, the entry is abandoned and no clock is gated. A monitor counts the cycles between a qualified wake and full clock restore, and flags an error if the count exceeds a parameter bound.

Top module: `pwrdn_seq`

## Requirements
- R1: After a valid entry request, clk_en stays 4'b1111 for as long as pipe_empty is low. Gating starts only after pipe_empty has been seen high.
- R2: lvl_sel encodes 0 = no level, 1 = doze, 2 = nap, 3 = sleep. Raising lvl_en with lvl_sel = 0 has no effect.
- R3: clk_en bit 0 is timebase/decrementer, bit 1 is snoop, bit 2 is data cache and bit 3 is the remaining core. When idle, clk_en is 4'b0111 in doze, 4'b0001 in nap and 4'b0000 in sleep. It is 4'b1111 at every other time, including right after reset.
- R4: For nap and sleep, qreq_n goes low once the pipeline is empty and stays low until wake. Gating begins only in the cycle after qack_n was sampled low. Doze never lowers qreq_n.
- R5: The five wake pins (bit 0 external interrupt, bit 1 system-management interrupt, bit 2 machine check, bit 3 soft reset, bit 4 hard reset) wake from every level. dec_irq wakes from doze and nap only.
- R6: In doze, snp_par_err or snp_bus_err causes a wake with the machine-check cause.
- R7: In the cycle after a qualified wake is sampled, clk_en is 4'b1111 and wake_vec_req is high for exactly one cycle.
- R8: wake_cause is 0 except while wake_vec_req is high. It then reads 1 = hard reset, 2 = soft reset, 3 = machine check (pin or doze snoop error), 4 = system-management interrupt, 5 = external interrupt, 6 = decrementer, and a higher-ranked cause wins when several are present together.
- R9: wake_lat_err rises if clocks are not fully restored within WAKE_MAX_CYC cycles of a qualified wake. In correct operation it stays low.
- R10: biu_resume is high after reset. It drops when nap or sleep is entered and rises again only after wake, once clk_sync has been sampled high.
- R11: In sleep, the wake pins are ignored while pll_lock is low.
- R12: A wake pin or dec_irq during draining or handshaking abandons the entry. The sequencer returns to run with qreq_n high, no clock gated and no vector request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Always-running control clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| lvl_en | input | 1 | Request to enter the level on lvl_sel |
| lvl_sel | input | 2 | Idle level code |
| pipe_empty | input | 1 | No instruction outstanding |
| qack_n | input | 1 | Active-low quiesce acknowledge from system |
| wake_pin | input | 5 | Wake pins, ranked as in R5/R8 |
| dec_irq | input | 1 | Decrementer interrupt |
| snp_par_err | input | 1 | Snoop address parity error |
| snp_bus_err | input | 1 | Bus error on snoop copyback |
| pll_lock | input | 1 | PLL locked after sleep |
| clk_sync | input | 1 | Bus and core clocks aligned |
| qreq_n | output | 1 | Active-low quiesce request |
| clk_en | output | 4 | Per-group clock enables |
| wake_vec_req | output | 1 | One-cycle vector jump request |
| wake_cause | output | 3 | Vector cause code |
| biu_resume | output | 1 | Bus interface may run |
| wake_lat_err | output | 1 | Wake latency bound exceeded |

## Verification
The bench targets entry while the pipeline is still busy. A design that gates early would drop clk_en before pipe_empty. It also holds back the acknowledge for several cycles; a sequencer that skips the handshake would gate during that window. Decrementer and unlocked-PLL pin events are applied in sleep, where a wrongly qualified wake would restore clocks. Simultaneous pins test the cause ranking, and a wrong priority shows up as a different code. Aborts during drain and handshake would leave qreq_n low or emit a spurious vector request if mishandled, and a missing clock-sync wait would release the bus interface too early.

// File: rtl/pwrdn_pkg.sv
package pwrdn_pkg;

   localparam int NUM_GRP  = 4;
   localparam int NUM_PIN  = 5;

   localparam int GRP_TB    = 0;
   localparam int GRP_SNOOP = 1;
   localparam int GRP_DC    = 2;
   localparam int GRP_CORE  = 3;

   localparam int PIN_EXT  = 0;
   localparam int PIN_SMI  = 1;
   localparam int PIN_MCP  = 2;
   localparam int PIN_SRST = 3;
   localparam int PIN_HRST = 4;

   typedef enum logic [1:0] {
      LVL_NONE  = 2'd0,
      LVL_DOZE  = 2'd1,
      LVL_NAP   = 2'd2,
      LVL_SLEEP = 2'd3
   } lvl_e;

   typedef enum logic [2:0] {
      ST_RUN   = 3'd0,
      ST_DRAIN = 3'd1,
      ST_HSHK  = 3'd2,
      ST_IDLE  = 3'd3,
      ST_WAKE  = 3'd4
   } seq_st_e;

   localparam logic [2:0] CAUSE_NONE = 3'd0;
   localparam logic [2:0] CAUSE_HRST = 3'd1;
   localparam logic [2:0] CAUSE_SRST = 3'd2;
   localparam logic [2:0] CAUSE_MCHK = 3'd3;
   localparam logic [2:0] CAUSE_SMI  = 3'd4;
   localparam logic [2:0] CAUSE_EXT  = 3'd5;
   localparam logic [2:0] CAUSE_DEC  = 3'd6;

   // Which clock group a level keeps alive while idle.
   function automatic logic grp_kept(input int grp, input lvl_e lvl);
      logic keep;
      keep = 1'b0;
      case (lvl)
         LVL_DOZE:  keep = (grp == GRP_TB) || (grp == GRP_SNOOP) || (grp == GRP_DC);
         LVL_NAP:   keep = (grp == GRP_TB);
         default:   keep = 1'b0;
      endcase
      return keep;
   endfunction

endpackage

// File: rtl/pwrdn_wake_sel.sv
module pwrdn_wake_sel
   import pwrdn_pkg::*;
(
   input  lvl_e                lvl_i,
   input  logic [NUM_PIN-1:0]  pin_i,
   input  logic                dec_i,
   input  logic                snp_par_i,
   input  logic                snp_bus_i,
   input  logic                lock_i,
   output logic                any_raw_o,
   output logic                qual_o,
   output logic [2:0]          cause_o
);

   logic pin_any;
   logic snp_mchk;

   assign pin_any   = |pin_i;
   assign snp_mchk  = (lvl_i == LVL_DOZE) && (snp_par_i || snp_bus_i);
   assign any_raw_o = pin_any || dec_i;

   always_comb begin
      case (lvl_i)
         LVL_DOZE:  qual_o = pin_any || dec_i || snp_mchk;
         LVL_NAP:   qual_o = pin_any || dec_i;
         LVL_SLEEP: qual_o = pin_any && lock_i;
         default:   qual_o = 1'b0;
      endcase
   end

   always_comb begin
      if (pin_i[PIN_HRST])                cause_o = CAUSE_HRST;
      else if (pin_i[PIN_SRST])           cause_o = CAUSE_SRST;
      else if (pin_i[PIN_MCP] || snp_mchk) cause_o = CAUSE_MCHK;
      else if (pin_i[PIN_SMI])            cause_o = CAUSE_SMI;
      else if (pin_i[PIN_EXT])            cause_o = CAUSE_EXT;
      else                                cause_o = CAUSE_DEC;
   end

endmodule

// File: rtl/pwrdn_fsm.sv
module pwrdn_fsm
   import pwrdn_pkg::*;
(
   input  logic       clk,
   input  logic       rst_n,
   input  logic       lvl_en_i,
   input  lvl_e       lvl_sel_i,
   input  logic       pipe_empty_i,
   input  logic       qack_n_i,
   input  logic       wake_raw_i,
   input  logic       wake_qual_i,
   input  logic [2:0] cause_i,
   input  logic       clk_sync_i,
   output seq_st_e    st_o,
   output lvl_e       lvl_o,
   output logic       qreq_n_o,
   output logic       vec_req_o,
   output logic [2:0] cause_o,
   output logic       biu_ok_o
);

   seq_st_e    st_q, st_d;
   lvl_e       lvl_q;
   logic [2:0] cause_q;
   logic       biu_q;

   always_comb begin
      st_d = st_q;
      case (st_q)
         ST_RUN:   if (lvl_en_i && (lvl_sel_i != LVL_NONE)) st_d = ST_DRAIN;
         ST_DRAIN: begin
            if (wake_raw_i)        st_d = ST_RUN;
            else if (pipe_empty_i) st_d = (lvl_q == LVL_DOZE) ? ST_IDLE : ST_HSHK;
         end
         ST_HSHK: begin
            if (wake_raw_i)     st_d = ST_RUN;
            else if (!qack_n_i) st_d = ST_IDLE;
         end
         ST_IDLE:  if (wake_qual_i) st_d = ST_WAKE;
         ST_WAKE:  st_d = ST_RUN;
         default:  st_d = ST_RUN;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q    <= ST_RUN;
         lvl_q   <= LVL_NONE;
         cause_q <= CAUSE_NONE;
         biu_q   <= 1'b1;
      end else begin
         st_q <= st_d;
         if (st_q == ST_RUN && st_d == ST_DRAIN)
            lvl_q <= lvl_sel_i;
         if (st_q == ST_IDLE && wake_qual_i)
            cause_q <= cause_i;
         if (st_q == ST_HSHK && !wake_raw_i && !qack_n_i)
            biu_q <= 1'b0;
         else if (st_q != ST_IDLE && clk_sync_i)
            biu_q <= 1'b1;
      end
   end

   assign st_o      = st_q;
   assign lvl_o     = lvl_q;
   assign vec_req_o = (st_q == ST_WAKE);
   assign cause_o   = (st_q == ST_WAKE) ? cause_q : CAUSE_NONE;
   assign biu_ok_o  = biu_q;
   assign qreq_n_o  = !((st_q == ST_HSHK) ||
                        (st_q == ST_IDLE && lvl_q != LVL_DOZE));

   // R4: deep idle is only reached after the acknowledge was sampled low
   assert_ack_before_idle_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (st_q == ST_IDLE && $past(st_q) == ST_HSHK) |-> $past(!qack_n_i));

   // R7: the vector request is a single-cycle pulse
   assert_vec_pulse_R7: assert property (@(posedge clk) disable iff (!rst_n)
      vec_req_o |=> !vec_req_o);

endmodule

// File: rtl/pwrdn_clkgate.sv
module pwrdn_clkgate
   import pwrdn_pkg::*;
#(
   parameter int GROUPS = NUM_GRP
)(
   input  seq_st_e           st_i,
   input  lvl_e              lvl_i,
   output logic [GROUPS-1:0] en_o
);

   logic idle;
   assign idle = (st_i == ST_IDLE);

   for (genvar g = 0; g < GROUPS; g++) begin : g_grp
      assign en_o[g] = !idle || grp_kept(g, lvl_i);
   end

endmodule

// File: rtl/pwrdn_lat_mon.sv
module pwrdn_lat_mon #(
   parameter int LIMIT = 10,
   localparam int CW   = $clog2(LIMIT + 2)
)(
   input  logic clk,
   input  logic rst_n,
   input  logic start_i,
   input  logic all_on_i,
   output logic err_o
);

   logic [CW-1:0] cnt_q;
   logic          busy_q;
   logic          err_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q  <= '0;
         busy_q <= 1'b0;
         err_q  <= 1'b0;
      end else if (start_i) begin
         cnt_q  <= CW'(1);
         busy_q <= 1'b1;
      end else if (busy_q) begin
         if (all_on_i) begin
            busy_q <= 1'b0;
         end else begin
            if (cnt_q < CW'(LIMIT + 1)) cnt_q <= cnt_q + 1'b1;
            if (cnt_q >= CW'(LIMIT))    err_q <= 1'b1;
         end
      end
   end

   assign err_o = err_q;

endmodule

// File: rtl/pwrdn_seq.sv
module pwrdn_seq
   import pwrdn_pkg::*;
#(
   parameter int WAKE_MAX_CYC = 10
)(
   input  logic                clk,
   input  logic                rst_n,
   input  logic                lvl_en,
   input  logic [1:0]          lvl_sel,
   input  logic                pipe_empty,
   input  logic                qack_n,
   input  logic [NUM_PIN-1:0]  wake_pin,
   input  logic                dec_irq,
   input  logic                snp_par_err,
   input  logic                snp_bus_err,
   input  logic                pll_lock,
   input  logic                clk_sync,
   output logic                qreq_n,
   output logic [NUM_GRP-1:0]  clk_en,
   output logic                wake_vec_req,
   output logic [2:0]          wake_cause,
   output logic                biu_resume,
   output logic                wake_lat_err
);

   if (WAKE_MAX_CYC < 1) begin : g_bad_bound
      $error("WAKE_MAX_CYC must be at least 1");
   end

   seq_st_e    st;
   lvl_e       lvl_q;
   logic       wake_raw, wake_qual;
   logic [2:0] cause_sel;

   pwrdn_wake_sel u_wake (
      .lvl_i     (lvl_q),
      .pin_i     (wake_pin),
      .dec_i     (dec_irq),
      .snp_par_i (snp_par_err),
      .snp_bus_i (snp_bus_err),
      .lock_i    (pll_lock),
      .any_raw_o (wake_raw),
      .qual_o    (wake_qual),
      .cause_o   (cause_sel)
   );

   pwrdn_fsm u_fsm (
      .clk          (clk),
      .rst_n        (rst_n),
      .lvl_en_i     (lvl_en),
      .lvl_sel_i    (lvl_e'(lvl_sel)),
      .pipe_empty_i (pipe_empty),
      .qack_n_i     (qack_n),
      .wake_raw_i   (wake_raw),
      .wake_qual_i  (wake_qual),
      .cause_i      (cause_sel),
      .clk_sync_i   (clk_sync),
      .st_o         (st),
      .lvl_o        (lvl_q),
      .qreq_n_o     (qreq_n),
      .vec_req_o    (wake_vec_req),
      .cause_o      (wake_cause),
      .biu_ok_o     (biu_resume)
   );

   pwrdn_clkgate #(.GROUPS(NUM_GRP)) u_gate (
      .st_i  (st),
      .lvl_i (lvl_q),
      .en_o  (clk_en)
   );

   pwrdn_lat_mon #(.LIMIT(WAKE_MAX_CYC)) u_lat (
      .clk      (clk),
      .rst_n    (rst_n),
      .start_i  (st == ST_IDLE && wake_qual),
      .all_on_i (&clk_en),
      .err_o    (wake_lat_err)
   );

   // R1: nothing is gated while draining or handshaking
   assert_no_gate_early_R1: assert property (@(posedge clk) disable iff (!rst_n)
      (st == ST_DRAIN || st == ST_HSHK) |-> (&clk_en));

   // R7: every group is running again one cycle after a qualified wake
   assert_restore_next_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (st == ST_IDLE && wake_qual) |=> (&clk_en));

   // R9: latency bound never exceeded
   assert_lat_bound_R9: assert property (@(posedge clk) disable iff (!rst_n)
      !wake_lat_err);

   // R10: bus interface held while in a deep idle level
   assert_biu_held_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (st == ST_IDLE && lvl_q != LVL_DOZE) |-> !biu_resume);

endmodule

// File: tb/pwrdn_seq_tb.sv
module pwrdn_seq_tb;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       lvl_en = 1'b0;
   logic [1:0] lvl_sel = 2'd0;
   logic       pipe_empty = 1'b1;
   logic       qack_n = 1'b1;
   logic [4:0] wake_pin = 5'd0;
   logic       dec_irq = 1'b0;
   logic       snp_par_err = 1'b0;
   logic       snp_bus_err = 1'b0;
   logic       pll_lock = 1'b1;
   logic       clk_sync = 1'b0;
   logic       qreq_n;
   logic [3:0] clk_en;
   logic       wake_vec_req;
   logic [2:0] wake_cause;
   logic       biu_resume;
   logic       wake_lat_err;

   int checks = 0;
   int errors = 0;

   always #5 clk = ~clk;

   pwrdn_seq u_dut (
      .clk(clk), .rst_n(rst_n), .lvl_en(lvl_en), .lvl_sel(lvl_sel),
      .pipe_empty(pipe_empty), .qack_n(qack_n), .wake_pin(wake_pin),
      .dec_irq(dec_irq), .snp_par_err(snp_par_err), .snp_bus_err(snp_bus_err),
      .pll_lock(pll_lock), .clk_sync(clk_sync), .qreq_n(qreq_n),
      .clk_en(clk_en), .wake_vec_req(wake_vec_req), .wake_cause(wake_cause),
      .biu_resume(biu_resume), .wake_lat_err(wake_lat_err)
   );

   task automatic chk(input string tag, input int act, input int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
      end
   endtask

   // Reference model: phase 0 run, 1 draining, 2 awaiting ack, 3 idle, 4 waking
   int m_ph = 0, m_lvl = 0, m_cause = 0;
   bit m_biu = 1'b1;

   function automatic int ref_cause(input int lvl);
      if (wake_pin[4]) return 1;
      if (wake_pin[3]) return 2;
      if (wake_pin[2] || (lvl == 1 && (snp_par_err || snp_bus_err))) return 3;
      if (wake_pin[1]) return 4;
      if (wake_pin[0]) return 5;
      return 6;
   endfunction

   always @(posedge clk) begin
      if (!rst_n) begin
         m_ph = 0; m_lvl = 0; m_cause = 0; m_biu = 1'b1;
      end else begin
         bit raw, qual;
         raw = (wake_pin != 0) || dec_irq;
         if (m_lvl == 1)      qual = raw || snp_par_err || snp_bus_err;
         else if (m_lvl == 2) qual = raw;
         else                 qual = (wake_pin != 0) && pll_lock;
         if (m_ph == 2 && !raw && !qack_n) m_biu = 1'b0;
         else if (m_ph != 3 && clk_sync)   m_biu = 1'b1;
         case (m_ph)
            0: if (lvl_en && lvl_sel != 0) begin m_lvl = lvl_sel; m_ph = 1; end
            1: if (raw) m_ph = 0; else if (pipe_empty) m_ph = (m_lvl == 1) ? 3 : 2;
            2: if (raw) m_ph = 0; else if (!qack_n) m_ph = 3;
            3: if (qual) begin m_cause = ref_cause(m_lvl); m_ph = 4; end
            default: m_ph = 0;
         endcase
      end
   end

   always @(negedge clk) begin
      if (rst_n) begin
         int e_en;
         e_en = 15;
         if (m_ph == 3) e_en = (m_lvl == 1) ? 7 : (m_lvl == 2) ? 1 : 0;
         chk("R3 clk_en model", clk_en, e_en);
         chk("R4 qreq_n model", qreq_n, !((m_ph == 2) || (m_ph == 3 && m_lvl != 1)));
         chk("R7 wake_vec_req model", wake_vec_req, m_ph == 4);
         chk("R8 wake_cause model", wake_cause, (m_ph == 4) ? m_cause : 0);
         chk("R10 biu_resume model", biu_resume, m_biu);
         chk("R9 wake_lat_err model", wake_lat_err, 0);
      end
   end

   task automatic step(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic enter(input logic [1:0] sel);
      lvl_sel = sel; lvl_en = 1'b1;
      step(1);
      lvl_en = 1'b0;
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      checks++; errors++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      step(3);
      rst_n = 1'b1;
      step(1);
      chk("R3 reset clk_en", clk_en, 15);
      chk("R4 reset qreq_n", qreq_n, 1);
      chk("R10 reset biu_resume", biu_resume, 1);

      // R2: level code 0 does nothing
      enter(2'd0); step(2);
      chk("R2 no level clk_en", clk_en, 15);

      // Doze, busy pipeline first (R1), decrementer wake (R5)
      pipe_empty = 1'b0;
      enter(2'd1); step(2);
      chk("R1 draining clk_en", clk_en, 15);
      pipe_empty = 1'b1; step(1);
      chk("R3 doze clk_en", clk_en, 7);
      chk("R4 doze no qreq", qreq_n, 1);
      dec_irq = 1'b1; step(1); dec_irq = 1'b0;
      chk("R7 wake restores clk_en", clk_en, 15);
      chk("R7 vector request", wake_vec_req, 1);
      chk("R5 decrementer doze cause", wake_cause, 6);
      step(1);
      chk("R7 vector pulse ends", wake_vec_req, 0);

      // R6: snoop errors in doze
      enter(2'd1); step(1);
      snp_par_err = 1'b1; step(1); snp_par_err = 1'b0;
      chk("R6 parity error cause", wake_cause, 3);
      step(1);
      enter(2'd1); step(1);
      snp_bus_err = 1'b1; step(1); snp_bus_err = 1'b0;
      chk("R6 bus error cause", wake_cause, 3);
      step(1);

      // Nap with delayed acknowledge (R4), biu sync (R10)
      enter(2'd2); step(1);
      chk("R4 nap qreq asserted", qreq_n, 0);
      step(2);
      chk("R4 waits for ack", clk_en, 15);
      qack_n = 1'b0; step(1); qack_n = 1'b1;
      chk("R3 nap clk_en", clk_en, 1);
      chk("R10 biu held in nap", biu_resume, 0);
      dec_irq = 1'b1; step(1); dec_irq = 1'b0;
      chk("R5 decrementer nap cause", wake_cause, 6);
      step(1);
      chk("R10 biu waits for sync", biu_resume, 0);
      clk_sync = 1'b1; step(1); clk_sync = 1'b0;
      chk("R10 biu after sync", biu_resume, 1);

      // Sleep: dec ignored (R5), pins ignored while unlocked (R11), ranking (R8)
      pll_lock = 1'b0;
      enter(2'd3); step(1);
      qack_n = 1'b0; step(1); qack_n = 1'b1;
      chk("R3 sleep clk_en", clk_en, 0);
      dec_irq = 1'b1; step(2); dec_irq = 1'b0;
      chk("R5 decrementer ignored in sleep", clk_en, 0);
      wake_pin = 5'b00001; step(2);
      chk("R11 pins ignored unlocked", clk_en, 0);
      chk("R11 no vector unlocked", wake_vec_req, 0);
      pll_lock = 1'b1; wake_pin = 5'b10001; step(1); wake_pin = 5'b0;
      chk("R8 hard reset outranks ext", wake_cause, 1);
      step(1);
      clk_sync = 1'b1; step(1); clk_sync = 1'b0;

      // R8: smi over ext in nap
      enter(2'd2); step(1);
      qack_n = 1'b0; step(1); qack_n = 1'b1;
      wake_pin = 5'b00011; step(1); wake_pin = 5'b0;
      chk("R8 smi outranks ext", wake_cause, 4);
      step(1);
      clk_sync = 1'b1; step(1); clk_sync = 1'b0;

      // R12: abort during drain and during handshake
      pipe_empty = 1'b0;
      enter(2'd2);
      wake_pin = 5'b00001; step(1); wake_pin = 5'b0;
      chk("R12 drain abort qreq_n", qreq_n, 1);
      chk("R12 drain abort clk_en", clk_en, 15);
      step(1);
      chk("R12 drain abort no vector", wake_vec_req, 0);
      pipe_empty = 1'b1;
      enter(2'd3); step(1);
      chk("R12 in handshake", qreq_n, 0);
      dec_irq = 1'b1; step(1); dec_irq = 1'b0;
      chk("R12 handshake abort qreq_n", qreq_n, 1);
      chk("R12 handshake abort clk_en", clk_en, 15);
      chk("R12 biu kept", biu_resume, 1);
      step(2);
      chk("R9 no latency error", wake_lat_err, 0);

      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

endmodule